// File: doc/BRIEF.md
# ESF CRC-6 Receive Checker

This block watches a received 1.544 Mb/s extended-superframe bit stream and reports whether each 4632-bit message block arrived intact. An external frame aligner supplies the serial bits with a qualifier and a start marker on bit 0 of each superframe. The checker runs a serial CRC-6 division over the block currently arriving. It forces every framing-bit position to 1 during the division. At the same time it picks up the six check bits carried in that superframe, which belong to the block before it.

When the last bit of a superframe is accepted, the remainder computed for the previous block is compared with the check bits just collected. In the next cycle the block raises a one-cycle result strobe with a pass/fail flag and updates a saturating errored-block counter. The start marker is optional once alignment is held: without it the position counters wrap on their own. A marker that arrives anywhere other than bit 0 restarts the position and cancels the next comparison.

Top module: `esf_crc6_rx_check`

## Requirements
- R1: A bit is accepted in a cycle where `bit_vld` is 1. `sf_start` together with `bit_vld` marks the accepted bit as position 0. Without it, positions advance by one per accepted bit and wrap from 4631 to 0. Bits accepted before the first `sf_start` after reset are ignored.
- R2: The remainder for a block equals the block polynomial, first-received bit as MSB, times x^6 and reduced modulo x^6+x+1, with the divider starting from all zeros at position 0.
- R3: Every position that is a multiple of 193 (0, 193, ..., 4439) enters the division as 1, whatever its received value.
- R4: The received check value is built from positions 193, 965, 1737, 2509, 3281 and 4053 of the following superframe, taken in that order as bits 5 down to 0.
- R5: In the cycle after position 4631 is accepted, `res_vld` is 1 for exactly one cycle. `res_err` is 1 then if and only if the received check value differs in any bit from the previous block's remainder.
- R6: An errored block raises `err_cnt` by exactly one, however many bits are wrong.
- R7: No result strobe is produced at the end of the first superframe after reset. None is produced either for a superframe that starts with an `sf_start` arriving at a position other than the expected position 0.
- R8: `err_cnt` stops at 2^CNT_W-1 and does not wrap.
- R9: `err_clr` sets `err_cnt` to 0 at the next clock edge and takes priority over an increment in the same cycle.
- R10: In cycles with `bit_vld` at 0, `bit_in` and `sf_start` are ignored and no position, remainder or result changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_vld | input | 1 | Qualifies `bit_in` and `sf_start` |
| bit_in | input | 1 | Received serial bit |
| sf_start | input | 1 | Current bit is position 0 of a superframe |
| err_clr | input | 1 | Synchronous clear of the error counter |
| res_vld | output | 1 | One-cycle result strobe |
| res_err | output | 1 | Previous block failed its check (valid with `res_vld`) |
| err_cnt | output | CNT_W | Saturating count of errored blocks |

## Verification
Random payload superframes carry check bits computed by a long-division model. Clean blocks show that the divider, the framing-bit substitution and the check-bit ordering agree with that model. A single flipped payload bit and a single flipped check bit each must give a failure, one strobe late, so an error in the block is told apart from an error in the carried check value. Flips on framing and data-link positions, a superframe without a start marker and an idle gap with a stray marker must all pass, which shows those inputs are ignored. A two-bit error counted once, a truncated superframe followed by a re-alignment, a narrow counter pushed past its ceiling and a clear that coincides with an increment cover the counter and resynchronisation rules.

// File: rtl/esf_crc6_pkg.sv
package esf_crc6_pkg;
   // per-bit position qualifiers for the bit currently being accepted
   typedef struct packed {
      logic first;   // position 0 of the superframe
      logic fbit;    // framing-bit position
      logic cbit;    // framing position carrying a check bit
      logic last;    // final position of the superframe
   } pos_flags_t;
endpackage

// File: rtl/esf_sf_tracker.sv
module esf_sf_tracker
   import esf_crc6_pkg::*;
#(
   parameter int FRAME_BITS = 193,
   parameter int SF_FRAMES  = 24,
   parameter int CB_STRIDE  = 4,
   parameter int CB_PHASE   = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_vld,
   input  logic       sf_start,
   output logic       active,
   output logic       resync,
   output pos_flags_t flags
);
   localparam int BW = $clog2(FRAME_BITS);
   localparam int FW = $clog2(SF_FRAMES);

   generate
      if (FRAME_BITS < 2)           begin : g_bad_frame  $error("FRAME_BITS too small"); end
      if (CB_PHASE >= CB_STRIDE)    begin : g_bad_phase  $error("CB_PHASE out of range"); end
      if (SF_FRAMES % CB_STRIDE != 0) begin : g_bad_stride $error("SF_FRAMES not a multiple of CB_STRIDE"); end
   endgenerate

   logic [BW-1:0] bit_q, eff_bit;
   logic [FW-1:0] frm_q, eff_frm;
   logic          locked_q;
   logic          last_bit, last_frm;

   always_comb begin
      eff_bit  = sf_start ? '0 : bit_q;
      eff_frm  = sf_start ? '0 : frm_q;
      last_bit = (eff_bit == BW'(FRAME_BITS - 1));
      last_frm = (eff_frm == FW'(SF_FRAMES - 1));
      active   = bit_vld && (locked_q || sf_start);
      resync   = bit_vld && sf_start && locked_q && ((bit_q != '0) || (frm_q != '0));
      flags.first = (eff_bit == '0) && (eff_frm == '0);
      flags.fbit  = (eff_bit == '0);
      flags.cbit  = (eff_bit == '0) && ((32'(eff_frm) % CB_STRIDE) == CB_PHASE);
      flags.last  = last_bit && last_frm;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_q    <= '0;
         frm_q    <= '0;
         locked_q <= 1'b0;
      end else if (active) begin
         locked_q <= 1'b1;
         if (last_bit) begin
            bit_q <= '0;
            frm_q <= last_frm ? '0 : eff_frm + FW'(1);
         end else begin
            bit_q <= eff_bit + BW'(1);
            frm_q <= eff_frm;
         end
      end
   end

   assert_idle_hold_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      !bit_vld |=> ($stable(bit_q) && $stable(frm_q) && $stable(locked_q)));

   assert_wrap_to_zero_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      (active && flags.last) |=> (bit_q == '0 && frm_q == '0));
endmodule

// File: rtl/esf_crc_divider.sv
module esf_crc_divider #(
   parameter int             W    = 6,
   parameter logic [W-1:0]   POLY = 6'b000011
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         start,
   input  logic         din,
   output logic [W-1:0] crc_next
);
   generate
      if (W < 2) begin : g_bad_w $error("divider width too small"); end
   endgenerate

   logic [W-1:0] crc_q, base;
   logic         fb;

   assign base = start ? '0 : crc_q;
   assign fb   = base[W-1] ^ din;

   // one serial step of the x^W-premultiplied division
   genvar i;
   generate
      for (i = 0; i < W; i++) begin : g_tap
         if (i == 0) begin : g_lsb
            assign crc_next[i] = POLY[i] & fb;
         end else begin : g_up
            assign crc_next[i] = base[i-1] ^ (POLY[i] & fb);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  crc_q <= '0;
      else if (en) crc_q <= crc_next;
   end

   assert_div_hold_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(crc_q));
endmodule

// File: rtl/esf_cb_capture.sv
module esf_cb_capture #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         din,
   output logic [W-1:0] cb
);
   // first carried bit ends up as MSB after W shifts
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cb <= '0;
      else if (en) cb <= {cb[W-2:0], din};
   end

   assert_cb_hold_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(cb));
endmodule

// File: rtl/esf_err_counter.sv
module esf_err_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   generate
      if (CNT_W < 1) begin : g_bad_cnt $error("CNT_W must be at least 1"); end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt <= '0;
      else if (clr)                    cnt <= '0;
      else if (inc && cnt != CNT_MAX)  cnt <= cnt + CNT_W'(1);
   end

   assert_no_overflow_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_MAX && !clr) |=> (cnt == CNT_MAX));

   assert_clear_wins_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));

   assert_single_step_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1)));
endmodule

// File: rtl/esf_crc6_rx_check.sv
module esf_crc6_rx_check
   import esf_crc6_pkg::*;
#(
   parameter int                FRAME_BITS = 193,
   parameter int                SF_FRAMES  = 24,
   parameter int                CB_STRIDE  = 4,
   parameter int                CB_PHASE   = 1,
   parameter int                CRC_W      = 6,
   parameter logic [CRC_W-1:0]  CRC_POLY   = 6'b000011,
   parameter int                CNT_W      = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_vld,
   input  logic             bit_in,
   input  logic             sf_start,
   input  logic             err_clr,
   output logic             res_vld,
   output logic             res_err,
   output logic [CNT_W-1:0] err_cnt
);
   generate
      if (SF_FRAMES / CB_STRIDE != CRC_W) begin : g_bad_cb_count
         $error("check-bit slots per superframe must equal CRC_W");
      end
   endgenerate

   pos_flags_t       flags;
   logic             active, resync;
   logic             div_in, blk_end, mismatch;
   logic [CRC_W-1:0] crc_next, cb_rx, prev_crc_q;
   logic             have_prev_q;

   esf_sf_tracker #(
      .FRAME_BITS(FRAME_BITS), .SF_FRAMES(SF_FRAMES),
      .CB_STRIDE(CB_STRIDE),   .CB_PHASE(CB_PHASE)
   ) u_track (
      .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .sf_start(sf_start),
      .active(active), .resync(resync), .flags(flags)
   );

   // framing positions are divided as ones
   assign div_in = flags.fbit ? 1'b1 : bit_in;

   esf_crc_divider #(.W(CRC_W), .POLY(CRC_POLY)) u_div (
      .clk(clk), .rst_n(rst_n), .en(active), .start(flags.first),
      .din(div_in), .crc_next(crc_next)
   );

   esf_cb_capture #(.W(CRC_W)) u_cb (
      .clk(clk), .rst_n(rst_n), .en(active && flags.cbit),
      .din(bit_in), .cb(cb_rx)
   );

   assign blk_end  = active && flags.last;
   assign mismatch = (cb_rx != prev_crc_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_prev_q <= 1'b0;
         prev_crc_q  <= '0;
         res_vld     <= 1'b0;
         res_err     <= 1'b0;
      end else begin
         res_vld <= blk_end && have_prev_q;
         res_err <= blk_end && have_prev_q && mismatch;
         if (resync) begin
            have_prev_q <= 1'b0;
         end else if (blk_end) begin
            have_prev_q <= 1'b1;
            prev_crc_q  <= crc_next;
         end
      end
   end

   esf_err_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(err_clr),
      .inc(blk_end && have_prev_q && mismatch), .cnt(err_cnt)
   );

   assert_strobe_single_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      res_vld |=> !res_vld);

   assert_err_needs_strobe_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      res_err |-> res_vld);

   assert_no_result_after_resync_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      resync |=> !res_vld);
endmodule

// File: tb/tb_esf_crc6_rx_check.sv
`timescale 1ns/1ps
module tb_esf_crc6_rx_check;
   localparam int SF_BITS = 4632;
   localparam int FB      = 193;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_vld = 1'b0, bit_in = 1'b0, sf_start = 1'b0, err_clr = 1'b0;
   logic res_vld, res_err, res_vld_s, res_err_s;
   logic [15:0] err_cnt;
   logic [1:0]  err_cnt_s;

   always #2.5 clk = ~clk;

   esf_crc6_rx_check dut (
      .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
      .sf_start(sf_start), .err_clr(err_clr),
      .res_vld(res_vld), .res_err(res_err), .err_cnt(err_cnt)
   );

   esf_crc6_rx_check #(.CNT_W(2)) dut_sat (
      .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
      .sf_start(sf_start), .err_clr(err_clr),
      .res_vld(res_vld_s), .res_err(res_err_s), .err_cnt(err_cnt_s)
   );

   int checks = 0, fails = 0;
   bit done = 1'b0;
   logic tx_bits [0:SF_BITS-1];
   logic rx_bits [0:SF_BITS-1];
   logic [5:0] prev_tx_crc = '0;   // clean remainder to insert in next superframe
   logic [5:0] prev_rx_crc = '0;   // remainder of what was actually received
   bit   prev_ok = 1'b0;
   int   exp_cnt = 0, exp_sat = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // long division with six appended zeros, framing positions taken as 1
   function automatic logic [5:0] ref_crc(input bit use_rx);
      logic [6:0] r = '0;
      for (int p = 0; p < SF_BITS + 6; p++) begin
         logic v;
         if (p >= SF_BITS)    v = 1'b0;
         else if (p % FB == 0) v = 1'b1;
         else                 v = use_rx ? rx_bits[p] : tx_bits[p];
         r = {r[5:0], v};
         if (r[6]) r = r ^ 7'h43;
      end
      return r[5:0];
   endfunction

   function automatic logic [5:0] rx_check_bits();
      logic [5:0] c;
      for (int k = 0; k < 6; k++) c[5-k] = rx_bits[FB * (1 + 4 * k)];
      return c;
   endfunction

   task automatic send_sf(input bit do_sof, input int flip_a, input int flip_b,
                          input int gap_at, input int abort_at, input bit clr_last,
                          input string note);
      int n;
      logic [5:0] cur_crc, rx_cb;
      bit exp_vld, exp_err;
      for (int p = 0; p < SF_BITS; p++) begin
         if (p % FB == 0 && ((p / FB) % 4) == 1)
            tx_bits[p] = prev_tx_crc[5 - ((p / FB) - 1) / 4];
         else
            tx_bits[p] = 1'($urandom);
         rx_bits[p] = tx_bits[p] ^ ((p == flip_a) || (p == flip_b));
      end
      cur_crc = ref_crc(1'b0);
      n = (abort_at >= 0) ? abort_at : SF_BITS;
      for (int p = 0; p < n; p++) begin
         if (p == gap_at) begin
            for (int g = 0; g < 3; g++) begin
               @(negedge clk);
               bit_vld = 1'b0; sf_start = 1'b1; bit_in = ~bit_in;
            end
         end
         @(negedge clk);
         bit_vld  = 1'b1;
         sf_start = (p == 0) && do_sof;
         bit_in   = rx_bits[p];
         err_clr  = clr_last && (p == SF_BITS - 1);
      end
      @(negedge clk);
      bit_vld = 1'b0; sf_start = 1'b0; err_clr = 1'b0;
      if (abort_at >= 0) begin
         chk(res_vld == 1'b0, "R7", {note, " truncated no strobe"}, res_vld, 0);
         prev_ok = 1'b0;
         return;
      end
      rx_cb   = rx_check_bits();
      exp_vld = prev_ok;
      exp_err = prev_ok && (rx_cb != prev_rx_crc);
      if (exp_err) begin
         exp_cnt = exp_cnt + 1;
         exp_sat = (exp_sat < 3) ? exp_sat + 1 : 3;
      end
      if (clr_last) begin exp_cnt = 0; exp_sat = 0; end
      chk(res_vld == exp_vld, "R5", {note, " strobe"}, res_vld, exp_vld);
      if (exp_vld)
         chk(res_err == exp_err, "R2", {note, " error flag"}, res_err, exp_err);
      chk(err_cnt == 16'(exp_cnt), "R6", {note, " count"}, err_cnt, exp_cnt);
      chk(err_cnt_s == 2'(exp_sat), "R8", {note, " saturating count"}, err_cnt_s, exp_sat);
      @(negedge clk);
      chk(res_vld == 1'b0, "R5", {note, " strobe one cycle"}, res_vld, 0);
      prev_rx_crc = ref_crc(1'b1);
      prev_tx_crc = cur_crc;
      prev_ok     = 1'b1;
   endtask

   task automatic check_reset();
      chk(res_vld == 1'b0, "R7", "reset strobe", res_vld, 0);
      chk(err_cnt == 16'd0, "R9", "reset count", err_cnt, 0);
   endtask

   task automatic send_junk(input int n);
      for (int p = 0; p < n; p++) begin
         @(negedge clk);
         bit_vld = 1'b1; sf_start = 1'b0; bit_in = 1'($urandom);
      end
      @(negedge clk);
      bit_vld = 1'b0;
      chk(res_vld == 1'b0, "R1", "pre-alignment bits ignored", res_vld, 0);
   endtask

   task automatic clear_counter();
      @(negedge clk); err_clr = 1'b1;
      @(negedge clk); err_clr = 1'b0;
      chk(err_cnt == 16'd0, "R9", "clear", err_cnt, 0);
      chk(err_cnt_s == 2'd0, "R9", "clear narrow", err_cnt_s, 0);
      exp_cnt = 0; exp_sat = 0;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      check_reset();
      rst_n = 1'b1;
      send_junk(100);
      send_sf(1, -1, -1, -1, -1, 0, "R7 first after reset");
      send_sf(1, -1, -1, -1, -1, 0, "R2 clean");
      send_sf(0, 386, 0, -1, -1, 0, "R1 no marker, R3 framing flips");
      send_sf(1, -1, -1, 1500, -1, 0, "R3 pass, R10 idle gap");
      send_sf(1, 1000, -1, -1, -1, 0, "payload flip sent");
      send_sf(1, -1, -1, -1, -1, 0, "R2 payload error seen");
      send_sf(1, 965, 3000, -1, -1, 0, "R4 check-bit flip");
      send_sf(1, 10, 2500, -1, -1, 0, "R2 payload error seen");
      send_sf(1, 40, -1, -1, -1, 0, "R6 two-bit block once");
      send_sf(1, 700, -1, -1, -1, 1, "R9 clear beats increment");
      send_sf(1, -1, -1, -1, -1, 0, "R2 error after clear");
      send_sf(1, -1, -1, -1, 2000, 0, "R7 truncated");
      send_sf(1, -1, -1, -1, -1, 0, "R7 realigned first");
      send_sf(1, -1, -1, -1, -1, 0, "R2 after realign");
      clear_counter();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule